// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the address stream for a four-beat burst to a pipelined cache memory. A burst opens when either of two address strobes is seen at a rising clock edge. One strobe comes from the processor and the other from the cache controller. The block registers the full starting address. After that, it steps the two least significant address bits once for each clock in which the advance input is high. The upper address bits stay at their captured value until the next strobe.

A static order input picks between two beat orders. The interleaved order is the starting low bits XOR the beat number. The linear order is the starting low bits plus the beat number, wrapping modulo four. A flag marks the fourth beat. The beat counter is two bits wide, so advancing past the fourth beat wraps back to the starting address. The order input is intended to be held constant while a burst is running.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addr_out` is all zeros and `last_beat` is 0.
- R2: When `strobe_ctrl` is 1 at a rising edge, `addr_out` equals the `addr_in` of that edge from the next cycle on, whatever `chip_sel` is, and `last_beat` is 0.
- R3: `strobe_proc` loads `addr_in` in the same way only when `chip_sel` is 1. When `chip_sel` is 0 it has no effect on `addr_out` or `last_beat`.
- R4: In a cycle with no accepted strobe and `advance` at 0, `addr_out` and `last_beat` keep their values.
- R5: With `order_lin` at 0 (interleaved), the low two bits of `addr_out` on beat n (n = 0..3) are the starting low bits XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R6: With `order_lin` at 1 (linear), the low two bits of `addr_out` on beat n are the starting low bits plus n, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R7: Bits `addr_out[ADDR_W-1:2]` are not changed by advancing and keep the captured value.
- R8: `last_beat` is 1 exactly on beat 3. One further advance returns `addr_out` to the starting address, with `last_beat` at 0.
- R9: An accepted strobe during a burst restarts at the new `addr_in` on beat 0, even when `advance` is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | Starting address, sampled when a strobe is accepted |
| strobe_proc | input | 1 | Processor address strobe, gated by `chip_sel` |
| strobe_ctrl | input | 1 | Controller address strobe, always accepted |
| chip_sel | input | 1 | First chip select, active high; qualifies `strobe_proc` only |
| advance | input | 1 | Step to the next beat |
| order_lin | input | 1 | 0 = interleaved order, 1 = linear order |
| addr_out | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High on the fourth beat |

## Verification
The bench runs both orders from a start of 01, where XOR and addition part ways on the second beat. A design that used one rule for both orders would give 00 instead of 10 in linear mode. It also advances past the fourth beat. A counter that saturated instead of wrapping would then stay on the last address with the flag stuck high. A processor strobe is raised with the chip select low to confirm nothing is loaded, while the controller strobe is used with the chip select low to confirm it still loads. A strobe is also raised together with `advance` partway through a burst. A design that gave `advance` priority would land on beat 1 of the new address rather than beat 0.

// File: rtl/bap_pkg.sv
package bap_pkg;
  localparam int unsigned BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic { ORD_XOR = 1'b0, ORD_LIN = 1'b1 } order_e;
endpackage

// File: rtl/bap_beat_ctr.sv
module bap_beat_ctr
  import bap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t beat,
  output logic  final_beat
);
  localparam beat_t BEAT_LAST = '1;

  beat_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + beat_t'(1);
  end

  assign beat       = cnt_q;
  assign final_beat = (cnt_q == BEAT_LAST);
endmodule

// File: rtl/bap_order.sv
module bap_order
  import bap_pkg::*;
(
  input  beat_t  start_lo,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  lo_out
);
  beat_t lo_xor;
  beat_t lo_sum;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign lo_xor[b] = start_lo[b] ^ beat[b];
  end

  assign lo_sum = start_lo + beat;

  always_comb begin
    lo_out = (order == ORD_LIN) ? lo_sum : lo_xor;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bap_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_proc,
  input  logic              strobe_ctrl,
  input  logic              chip_sel,
  input  logic              advance,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic              take;
  logic [ADDR_W-1:0] base_q;
  beat_t             beat;
  beat_t             lo_now;
  order_e            order;

  // controller strobe is never gated; processor strobe needs chip select
  assign take  = strobe_ctrl | (strobe_proc & chip_sel);
  assign order = order_lin ? ORD_LIN : ORD_XOR;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (take) base_q <= addr_in;
  end

  bap_beat_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .step       (advance),
    .beat       (beat),
    .final_beat (last_beat)
  );

  bap_order u_ord (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat),
    .order    (order),
    .lo_out   (lo_now)
  );

  assign addr_out = {base_q[ADDR_W-1 -: HI_W], lo_now};
endmodule

// File: rtl/bap_chk.sv
module bap_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_proc,
  input logic              strobe_ctrl,
  input logic              chip_sel,
  input logic              advance,
  input logic              order_lin,
  input logic [ADDR_W-1:0] addr_out,
  input logic              last_beat
);
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ctrl |=> (addr_out == $past(addr_in)) && !last_beat);

  // R3
  proc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc && !chip_sel && !strobe_ctrl && !advance) |=>
      ($stable(last_beat) && ((order_lin != $past(order_lin)) || $stable(addr_out))));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_ctrl && !strobe_proc && !advance) |=>
      ($stable(last_beat) && ((order_lin != $past(order_lin)) || $stable(addr_out))));

  // R6
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_ctrl && !strobe_proc && advance && order_lin) |=>
      (!order_lin || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_ctrl && !(strobe_proc && chip_sel)) |=>
      (addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_proc && chip_sel && advance) |=> (addr_out == $past(addr_in)));
endmodule

bind burst_addr_seq bap_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_in     (addr_in),
  .strobe_proc (strobe_proc),
  .strobe_ctrl (strobe_ctrl),
  .chip_sel    (chip_sel),
  .advance     (advance),
  .order_lin   (order_lin),
  .addr_out    (addr_out),
  .last_beat   (last_beat)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int unsigned AW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          strobe_proc, strobe_ctrl, chip_sel, advance, order_lin;
  logic [AW-1:0] addr_out;
  logic          last_beat;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl),
    .chip_sel(chip_sel), .advance(advance), .order_lin(order_lin),
    .addr_out(addr_out), .last_beat(last_beat)
  );

  task automatic check(string req, logic [AW-1:0] act_a, logic [AW-1:0] exp_a,
                       logic act_l, logic exp_l);
    total++;
    if (act_a !== exp_a || act_l !== exp_l) begin
      bad++;
      $display("FAIL %s: addr=%h last=%b expected addr=%h last=%b",
               req, act_a, act_l, exp_a, exp_l);
    end
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] start, int n, logic lin);
    logic [1:0] lo;
    lo = lin ? 2'(start[1:0] + 2'(n)) : (start[1:0] ^ 2'(n));
    return {start[AW-1:2], lo};
  endfunction

  // drive on negedge, registers update on posedge, check at following negedge
  task automatic cycle(logic sp, logic sc, logic cs, logic adv, logic [AW-1:0] a);
    strobe_proc = sp; strobe_ctrl = sc; chip_sel = cs; advance = adv; addr_in = a;
    @(negedge clk);
    strobe_proc = 0; strobe_ctrl = 0; advance = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; strobe_proc = 0; strobe_ctrl = 0; chip_sel = 0;
    advance = 0; order_lin = 0; addr_in = '1;
    repeat (3) @(negedge clk);
    check("R1", addr_out, '0, last_beat, 1'b0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_burst(logic lin, logic [AW-1:0] start, string req);
    order_lin = lin;
    cycle(0, 1, 0, 0, start);
    check("R2", addr_out, start, last_beat, 1'b0);
    for (int n = 1; n < 4; n++) begin
      cycle(0, 0, 0, 1, '0);
      check(req, addr_out, expect_addr(start, n, lin), last_beat, n == 3);
    end
    cycle(0, 0, 0, 1, '0);
    check("R8", addr_out, start, last_beat, 1'b0);
  endtask

  task automatic t_proc_gate();
    logic [AW-1:0] s = 18'h2A5F4;
    order_lin = 0;
    cycle(1, 0, 1, 0, s);
    check("R3", addr_out, s, last_beat, 1'b0);
    cycle(0, 0, 0, 1, '0);
    cycle(1, 0, 0, 0, 18'h01235);
    check("R3", addr_out, expect_addr(s, 1, 0), last_beat, 1'b0);
  endtask

  task automatic t_hold();
    logic [AW-1:0] s = 18'h10002;
    order_lin = 1;
    cycle(0, 1, 1, 0, s);
    cycle(0, 0, 1, 1, '0);
    for (int k = 0; k < 3; k++) begin
      cycle(0, 0, 1, 0, 18'h3FFFF);
      check("R4", addr_out, expect_addr(s, 1, 1), last_beat, 1'b0);
    end
    cycle(0, 0, 1, 1, '0);
    check("R7", addr_out, expect_addr(s, 2, 1), last_beat, 1'b0);
  endtask

  task automatic t_restart();
    logic [AW-1:0] s1 = 18'h0F0F0;
    logic [AW-1:0] s2 = 18'h33333;
    order_lin = 0;
    cycle(0, 1, 0, 0, s1);
    cycle(0, 0, 0, 1, '0);
    cycle(0, 0, 0, 1, '0);
    cycle(1, 0, 1, 1, s2);
    check("R9", addr_out, s2, last_beat, 1'b0);
    cycle(0, 0, 0, 1, '0);
    check("R9", addr_out, expect_addr(s2, 1, 0), last_beat, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_burst(0, 18'h12341, "R5");
    t_burst(1, 18'h12341, "R6");
    t_burst(0, 18'h3ABC2, "R5");
    t_burst(1, 18'h00003, "R6");
    t_proc_gate();
    t_hold();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule